// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Port with Error Flags

This block is a synchronous serial port that exchanges one byte at a time with an external device over the usual four wires: clock, data out, data in and an active-low select. A small register bus gives software a control register, a data register and a status register. The control register holds two sticky error bits, an enable bit, a clock-polarity bit and a 4-bit mode code. The mode code selects the role (master or slave) and the clock source.

In master mode the port makes the serial clock itself. The clock comes from one of three fixed divisions of the system clock or from an external timer pulse. A write to the data register starts a transfer. In slave mode the external device supplies the clock, and the select pin can optionally frame each byte. Received bytes land in the data register and raise a full flag. A data write during a transfer, or a new byte that arrives while the last one is still unread, is caught by one of the sticky error bits.

Top module: `spi_port`

## Requirements
- R1: Mode codes 0 (0000), 1 (0001) and 2 (0010) select master mode. In these modes the serial clock changes level every 2, 8 and 32 system clocks respectively while a transfer runs, and a transfer takes 16 clock changes.
- R2: Mode code 3 (0011) selects master mode with the serial clock changing level once for each timer pulse. A full clock period therefore takes two pulses.
- R3: Mode code 4 (0100) selects slave mode with select gating. While the select pin is high, the bit counter is held at zero, incoming clock edges are ignored, busy (status bit 1) reads 0 and data out is not driven. Mode code 5 (0101) selects slave mode that ignores the select pin and always drives data out.
- R4: Control bit 4 sets the serial clock idle level: 1 is idle high and 0 is idle low. In both master and slave modes, the clock change away from this level is the leading edge.
- R5: A data-register write while a transfer is in progress sets control bit 7, the collision flag. That write is ignored and the byte in flight goes out unchanged. The flag stays set until software writes 0 to bit 7, and writing 1 to bit 7 never sets it.
- R6: In slave mode, if a byte finishes arriving while the full flag is set, control bit 6 (the overflow flag) is set and the new byte is discarded. The data register keeps the old byte. The flag clears only when software writes 0 to bit 6.
- R7: In master modes the overflow flag is never set. Every completed byte replaces the data register.
- R8: With control bit 5 (enable) at 0, neither the clock output nor data out is driven, and data writes start nothing. With enable at 1 in master mode the clock output is driven.
- R9: Data moves most significant bit first. Data out changes on the leading edge and data in is sampled on the trailing edge. The byte transmitted is the byte written to the data register (address 1).
- R10: Status bit 0 (full, address 2) goes to 1 when a received byte is moved into the data register. It returns to 0 after a read strobe on address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; only a read of the data register has a side effect |
| bus_addr | input | 2 | Register select: 0 control, 1 data, 2 status |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data, combinational from bus_addr |
| tmr_pulse | input | 1 | Single-cycle timer pulse used as the clock source in mode 3 |
| sck_i | input | 1 | Serial clock from the pin (slave modes) |
| sck_o | output | 1 | Serial clock to the pin (master modes) |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for data out |
| sdi_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Active-low slave select from the pin |

## Verification
Master transfers run at each of the three divided rates with different byte pairs. The measured spacing between clock changes separates the rates from one another, and asymmetric byte patterns expose a reversed or rotated bit order. The timer-driven mode runs from a pulse train whose period matches none of the divided rates, so a clock that ignores the pulses shows up in the spacing. In slave mode the bench supplies clocks at both polarities. It interrupts a byte with the select pin to show that the counter restarts, repeats the transfer with select high in the ungated mode, and sends a second unread byte to tell overflow apart from overwrite. Writes during a transfer, with enable at 0, and with the error bits set to 1 confirm that the data in flight and the sticky flags stay unchanged.

// File: rtl/spi_port_pkg.sv
// Shared definitions for the serial port: register addresses, mode codes
// and the control register layout.
package spi_port_pkg;

    // Register addresses on the local bus
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DATA = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    // Mode codes held in the low nibble of the control register
    localparam logic [3:0] MODE_M_FAST = 4'b0000;
    localparam logic [3:0] MODE_M_MID  = 4'b0001;
    localparam logic [3:0] MODE_M_SLOW = 4'b0010;
    localparam logic [3:0] MODE_M_TMR  = 4'b0011;
    localparam logic [3:0] MODE_S_SEL  = 4'b0100;
    localparam logic [3:0] MODE_S_FREE = 4'b0101;

    // Control register, bit 7 down to bit 0
    typedef struct packed {
        logic       wcol;   // sticky write-collision flag
        logic       ovf;    // sticky receive-overflow flag
        logic       en;     // port enable
        logic       cpol;   // serial clock idle level
        logic [3:0] mode;   // role and clock source
    } ctrl_t;

endpackage

// File: rtl/spi_clkgen.sv
// Master bit-clock pacing. Produces a one-cycle half_tick each time the
// serial clock has to change level. A divided rate or the external timer
// pulse sets the pace.
// Assumes: every DIV_* is even and at least 4, and tmr_pulse is a
// single-cycle pulse synchronous to clk.
module spi_clkgen #(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int DIV_C = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    input  logic       use_tmr,
    input  logic       tmr_pulse,
    output logic       half_tick
);
    localparam int HALF_A = DIV_A / 2;
    localparam int HALF_B = DIV_B / 2;
    localparam int HALF_C = DIV_C / 2;
    localparam int CW     = $clog2(HALF_C) + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Pick the terminal count for the selected divided rate
    always_comb begin
        case (rate)
            2'd0:    lim = CW'(HALF_A - 1);
            2'd1:    lim = CW'(HALF_B - 1);
            default: lim = CW'(HALF_C - 1);
        endcase
    end

    assign half_tick = run && (use_tmr ? tmr_pulse : (cnt_q == lim));

    // Count system clocks within one half period, restarting at each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || half_tick || use_tmr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1: a divided half period always lasts at least two system clocks
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (half_tick && !use_tmr) |=> !half_tick);

endmodule

// File: rtl/spi_shifter.sv
// Shift engine shared by both roles. Leading edges put the next bit on
// data out. Trailing edges sample data in, shift it in and count it.
// In master mode the edges come from half_tick. In slave mode they come
// from the synchronised pin clock.
// Assumes: load is raised only while busy is low, and clear is held
// while the port is disabled.
module spi_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            is_master,
    input  logic            cpol,
    input  logic            half_tick,
    input  logic            sck_s,
    input  logic            sdi_s,
    input  logic            sdi_raw,
    input  logic            ss_hold,
    input  logic            load,
    input  logic [BITS-1:0] load_data,
    output logic            busy,
    output logic            running,
    output logic            done,
    output logic [BITS-1:0] rx_byte,
    output logic            sck_q,
    output logic            sdo_q
);
    localparam int CW = $clog2(BITS);

    logic [BITS-1:0] sh_q;
    logic [CW-1:0]   cnt_q;
    logic            phase_q;
    logic            m_act_q;
    logic            sck_prev_q;
    logic            sdo_r;

    logic m_lead, m_trail, s_edge, s_lead, s_trail;
    logic lead, trail, din, last;

    // Classify the current cycle's clock event for either role
    always_comb begin
        m_lead  = is_master && m_act_q && half_tick && !phase_q;
        m_trail = is_master && m_act_q && half_tick &&  phase_q;
        s_edge  = !is_master && !ss_hold && (sck_s != sck_prev_q);
        s_lead  = s_edge && (sck_s != cpol);
        s_trail = s_edge && (sck_s == cpol);
        lead    = m_lead  || s_lead;
        trail   = m_trail || s_trail;
        din     = is_master ? sdi_raw : sdi_s;
        last    = (cnt_q == CW'(BITS - 1));
    end

    assign done    = trail && last;
    assign rx_byte = {sh_q[BITS-2:0], din};
    assign busy    = m_act_q || (cnt_q != '0);
    assign running = m_act_q;
    assign sck_q   = cpol ^ phase_q;
    assign sdo_q   = sdo_r;

    // Shift register, bit counter, master phase and data-out register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            phase_q    <= 1'b0;
            m_act_q    <= 1'b0;
            sck_prev_q <= 1'b0;
            sdo_r      <= 1'b0;
        end else if (clear) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            phase_q    <= 1'b0;
            m_act_q    <= 1'b0;
            sck_prev_q <= sck_s;
            sdo_r      <= 1'b0;
        end else begin
            sck_prev_q <= sck_s;
            if (load) begin
                sh_q    <= load_data;
                sdo_r   <= load_data[BITS-1];
                m_act_q <= is_master;
                phase_q <= 1'b0;
            end else begin
                if (lead) begin
                    sdo_r <= sh_q[BITS-1];
                end
                if (trail) begin
                    sh_q  <= {sh_q[BITS-2:0], din};
                    cnt_q <= last ? '0 : cnt_q + 1'b1;
                end
                if (m_lead || m_trail) begin
                    phase_q <= ~phase_q;
                end
                if (done && is_master) begin
                    m_act_q <= 1'b0;
                end
            end
            if (ss_hold) begin
                cnt_q <= '0;
            end
        end
    end

    // R3: a raised, gated select leaves the bit counter at zero
    p_ss_resets_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ss_hold |=> (cnt_q == '0));

    // R4: an idle master holds the clock at its idle level
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !m_act_q) |-> (sck_q == cpol));

    // R9: the last trailing edge ends a master transfer at the idle level
    p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_master && !clear) |=> (!busy && sck_q == cpol));

endmodule

// File: rtl/spi_regs.sv
// Register file: control, data and status registers; start of transfers;
// the sticky collision and overflow flags; the full flag.
// Assumes: bus strobes last one cycle, and busy and done come from the
// shift engine in the same cycle.
module spi_regs
    import spi_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          mode_ok,
    input  logic          is_master,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] rx_byte,
    output ctrl_t         ctrl,
    output logic          load,
    output logic [DW-1:0] load_data
);
    logic          full_q;
    logic [DW-1:0] hold_q;
    logic          wr_ctrl, wr_data, rd_data, port_on, coll, full_eff;

    // Decode bus strobes and the transfer start or collision condition
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
        wr_data  = bus_wr && (bus_addr == A_DATA);
        rd_data  = bus_rd && (bus_addr == A_DATA);
        port_on  = ctrl.en && mode_ok;
        load     = wr_data && port_on && !busy;
        coll     = wr_data && port_on && busy;
        full_eff = full_q && !rd_data;
    end

    assign load_data = bus_wdata;

    // Control register with clear-only error bits that any event can set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en   <= bus_wdata[5];
                ctrl.cpol <= bus_wdata[4];
                ctrl.mode <= bus_wdata[3:0];
                ctrl.wcol <= ctrl.wcol & bus_wdata[7];
                ctrl.ovf  <= ctrl.ovf  & bus_wdata[6];
            end
            if (coll) begin
                ctrl.wcol <= 1'b1;
            end
            if (done && !is_master && full_eff) begin
                ctrl.ovf <= 1'b1;
            end
        end
    end

    // Receive holding register and its full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            full_q <= 1'b0;
        end else begin
            if (rd_data) begin
                full_q <= 1'b0;
            end
            if (done && (is_master || !full_eff)) begin
                hold_q <= rx_byte;
                full_q <= 1'b1;
            end
        end
    end

    // Read data multiplexer
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = DW'(ctrl);
            A_DATA:  bus_rdata = hold_q;
            A_STAT:  bus_rdata = DW'({busy, full_q});
            default: bus_rdata = '0;
        endcase
    end

    // R5: collision flag survives everything but a control write
    p_wcol_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.wcol && !wr_ctrl) |=> ctrl.wcol);

    // R6: an overrun leaves the held byte untouched
    p_ovf_keeps_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_master && full_q && !rd_data) |=> $stable(hold_q));

    // R7: master operation never raises the overflow flag
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !ctrl.ovf) |=> !ctrl.ovf);

    // R10: reading the data register empties it unless a byte lands
    p_full_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !done) |=> !full_q);

endmodule

// File: rtl/spi_port.sv
// Top of the serial port. Synchronises the pin inputs, decodes the mode
// field into role, clock source and select gating, and drives the pin
// enables.
// Assumes: sck_i, sdi_i and ss_n_i are asynchronous to clk and change no
// faster than every SYNC_STAGES+1 system clocks.
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DW          = 8,
    parameter int DIV_A       = 4,
    parameter int DIV_B       = 16,
    parameter int DIV_C       = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          tmr_pulse,
    input  logic          sck_i,
    output logic          sck_o,
    output logic          sck_oe,
    output logic          sdo_o,
    output logic          sdo_oe,
    input  logic          sdi_i,
    input  logic          ss_n_i
);
    ctrl_t         ctrl;
    logic          mode_ok, is_master, use_tmr, port_on, ss_hold;
    logic          busy, running, done, load, half_tick;
    logic          sck_s, sdi_s, ss_s, sck_q, sdo_q;
    logic [DW-1:0] load_data, rx_byte;

    logic [SYNC_STAGES-1:0][2:0] sync_q;

    // Bring the three pin inputs into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {SYNC_STAGES{3'b100}};
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], {ss_n_i, sdi_i, sck_i}};
        end
    end

    assign {ss_s, sdi_s, sck_s} = sync_q[SYNC_STAGES-1];

    // Decode role, clock source, gating and pin ownership
    always_comb begin
        mode_ok   = (ctrl.mode <= MODE_S_FREE);
        is_master = (ctrl.mode[3:2] == 2'b00);
        use_tmr   = (ctrl.mode == MODE_M_TMR);
        port_on   = ctrl.en && mode_ok;
        ss_hold   = (ctrl.mode == MODE_S_SEL) && ss_s;
        sck_oe    = port_on && is_master;
        sdo_oe    = port_on && (is_master || (ctrl.mode == MODE_S_FREE) ||
                                ((ctrl.mode == MODE_S_SEL) && !ss_s));
        sck_o     = is_master ? sck_q : ctrl.cpol;
        sdo_o     = sdo_q;
    end

    spi_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mode_ok   (mode_ok),
        .is_master (is_master),
        .busy      (busy),
        .done      (done),
        .rx_byte   (rx_byte),
        .ctrl      (ctrl),
        .load      (load),
        .load_data (load_data)
    );

    spi_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (running),
        .rate      (ctrl.mode[1:0]),
        .use_tmr   (use_tmr),
        .tmr_pulse (tmr_pulse),
        .half_tick (half_tick)
    );

    spi_shifter #(.BITS(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (!port_on),
        .is_master (is_master),
        .cpol      (ctrl.cpol),
        .half_tick (half_tick),
        .sck_s     (sck_s),
        .sdi_s     (sdi_s),
        .sdi_raw   (sdi_i),
        .ss_hold   (ss_hold),
        .load      (load),
        .load_data (load_data),
        .busy      (busy),
        .running   (running),
        .done      (done),
        .rx_byte   (rx_byte),
        .sck_q     (sck_q),
        .sdo_q     (sdo_q)
    );

    // R8: a disabled port drives neither the clock nor data out
    p_oe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> (!sck_oe && !sdo_oe));

endmodule

// File: tb/spi_port_tb.sv
// Bench for spi_port. A clocked monitor models the pin enables each
// cycle and acts as the far end of master transfers. Tasks act as the
// master for slave-mode transfers.
module spi_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_pulse = 1'b0;
    logic       sck_i = 1'b0, sdi_i = 1'b0, ss_n_i = 1'b1;
    logic       sck_o, sck_oe, sdo_o, sdo_oe;

    int checks = 0, errors = 0;

    // Shadow of the control register, kept by the write task
    logic       sh_en = 1'b0, sh_cpol = 1'b0;
    logic [3:0] sh_mode = 4'd0;

    // Far-end model for master transfers
    logic [7:0] m_tx = 8'h00, m_rx = 8'h00;
    int m_bits = 0, toggles = 0, gap_bad = 0, half_exp = 2;
    int cyc = 0, last_tog = 0;
    logic last_sck = 1'b0, prev_ss = 1'b1;
    bit tmr_on = 1'b0;
    int tcnt = 0;

    always #10 clk = ~clk;

    spi_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_pulse(tmr_pulse), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i), .ss_n_i(ss_n_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-cycle model: pin enables, clock spacing and far-end data
    always @(posedge clk) begin
        #2;
        cyc++;
        if (rst_n) begin
            logic exp_sck_oe, exp_sdo_oe, valid;
            valid      = sh_en && (sh_mode <= 4'd5);
            exp_sck_oe = valid && (sh_mode <= 4'd3);
            exp_sdo_oe = valid && ((sh_mode <= 4'd3) || (sh_mode == 4'd5) ||
                                   ((sh_mode == 4'd4) && !prev_ss));
            if (sck_oe !== exp_sck_oe)
                chk(0, "R8", "sck_oe per cycle", int'(sck_oe), int'(exp_sck_oe));
            if (sdo_oe !== exp_sdo_oe)
                chk(0, "R3/R8", "sdo_oe per cycle", int'(sdo_oe), int'(exp_sdo_oe));
            if (sck_oe && (sck_o != last_sck)) begin
                if (toggles > 0 && (cyc - last_tog) != half_exp) gap_bad++;
                last_tog = cyc;
                toggles++;
                if (sck_o != sh_cpol) begin
                    if (m_bits < 8) sdi_i = m_tx[7 - m_bits];
                end else begin
                    m_rx = {m_rx[6:0], sdo_o};
                    m_bits++;
                end
            end
        end
        last_sck = sck_o;
        prev_ss  = ss_n_i;
    end

    // Timer pulse train: one pulse every 5 system clocks when enabled
    always @(negedge clk) begin
        if (tmr_on) begin
            tcnt++;
            tmr_pulse <= (tcnt % 5 == 0);
        end else begin
            tcnt = 0;
            tmr_pulse <= 1'b0;
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        if (a == 2'd0) begin
            sh_en = d[5]; sh_cpol = d[4]; sh_mode = d[3:0];
        end
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, input bit pop, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = pop;
        #1 d = bus_rdata;
        if (pop) begin
            @(negedge clk);
            bus_rd = 1'b0;
        end
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            reg_rd(2'd2, 1'b0, s);
            if (!s[1]) break;
        end
    endtask

    task automatic mxfer(input logic [7:0] tx, input logic [7:0] pat, input int half);
        m_tx = pat; m_rx = 8'h00; m_bits = 0; toggles = 0; gap_bad = 0;
        half_exp = half;
        reg_wr(2'd1, tx);
        wait_idle();
    endtask

    task automatic sclk_bit(input logic b, input logic cpol, output logic got);
        @(negedge clk);
        sck_i = ~cpol; sdi_i = b;
        repeat (6) @(negedge clk);
        got = sdo_o;
        sck_i = cpol;
        repeat (6) @(negedge clk);
    endtask

    task automatic sxfer(input logic [7:0] mosi, input logic cpol, output logic [7:0] miso);
        logic g;
        for (int i = 0; i < 8; i++) begin
            sclk_bit(mosi[7 - i], cpol, g);
            miso[7 - i] = g;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "WATCHDOG", "run did not finish", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, s, miso;
        logic g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Reset state (R8, R10)
        reg_rd(2'd0, 0, d); chk(d == 8'h00, "R8", "ctrl after reset", d, 8'h00);
        reg_rd(2'd2, 0, s); chk(s == 8'h00, "R10", "status after reset", s, 8'h00);
        chk(!sck_oe && !sdo_oe, "R8", "pins undriven after reset", {sck_oe, sdo_oe}, 0);

        // Master at the fastest rate (R1, R9, R10)
        reg_wr(2'd0, 8'h20);
        mxfer(8'hA5, 8'h3C, 2);
        chk(toggles == 16 && gap_bad == 0, "R1", "div4 clock changes/gaps", toggles*100+gap_bad, 1600);
        chk(m_rx == 8'hA5, "R9", "div4 bits sent MSB first", m_rx, 8'hA5);
        reg_rd(2'd2, 0, s); chk(s[0] == 1'b1, "R10", "full after receive", s, 1);
        reg_rd(2'd1, 1, d); chk(d == 8'h3C, "R9", "div4 byte received", d, 8'h3C);
        reg_rd(2'd2, 0, s); chk(s[0] == 1'b0, "R10", "full cleared by read", s, 0);

        // Master at the middle and slowest rates (R1)
        reg_wr(2'd0, 8'h21);
        mxfer(8'h4E, 8'hB1, 8);
        chk(toggles == 16 && gap_bad == 0, "R1", "div16 clock changes/gaps", toggles*100+gap_bad, 1600);
        chk(m_rx == 8'h4E, "R1", "div16 bits sent", m_rx, 8'h4E);
        reg_rd(2'd1, 1, d); chk(d == 8'hB1, "R1", "div16 byte received", d, 8'hB1);
        reg_wr(2'd0, 8'h22);
        mxfer(8'h0F, 8'hF0, 32);
        chk(toggles == 16 && gap_bad == 0, "R1", "div64 clock changes/gaps", toggles*100+gap_bad, 1600);
        reg_rd(2'd1, 1, d); chk(d == 8'hF0 && m_rx == 8'h0F, "R1", "div64 exchange", {d, m_rx}, 16'hF00F);

        // Clock polarity (R4)
        reg_wr(2'd0, 8'h30);
        repeat (2) @(negedge clk);
        chk(sck_o == 1'b1, "R4", "idle high with polarity 1", sck_o, 1);
        mxfer(8'hC6, 8'h59, 2);
        chk(m_rx == 8'hC6 && gap_bad == 0, "R4", "polarity 1 bits sent", m_rx, 8'hC6);
        reg_rd(2'd1, 1, d); chk(d == 8'h59, "R4", "polarity 1 byte received", d, 8'h59);
        chk(sck_o == 1'b1, "R4", "back to idle high", sck_o, 1);
        reg_wr(2'd0, 8'h20);
        repeat (2) @(negedge clk);
        chk(sck_o == 1'b0, "R4", "idle low with polarity 0", sck_o, 0);

        // Master overwrite never overflows (R7)
        mxfer(8'h11, 8'h22, 2);
        mxfer(8'h33, 8'h44, 2);
        reg_rd(2'd0, 0, d); chk(d[6] == 1'b0, "R7", "no overflow in master", d, 8'h20);
        reg_rd(2'd1, 1, d); chk(d == 8'h44, "R7", "second byte replaces first", d, 8'h44);

        // Collision (R5)
        reg_wr(2'd0, 8'h21);
        m_tx = 8'h6D; m_rx = 8'h00; m_bits = 0; toggles = 0; gap_bad = 0; half_exp = 8;
        reg_wr(2'd1, 8'h81);
        repeat (20) @(negedge clk);
        reg_wr(2'd1, 8'hFF);
        reg_rd(2'd0, 0, d); chk(d[7] == 1'b1, "R5", "collision flag set", d, 8'hA1);
        wait_idle();
        chk(m_rx == 8'h81 && gap_bad == 0, "R5", "byte in flight unchanged", m_rx, 8'h81);
        reg_rd(2'd1, 1, d); chk(d == 8'h6D, "R5", "receive unaffected", d, 8'h6D);
        reg_rd(2'd0, 0, d); chk(d == 8'hA1, "R5", "collision flag sticky", d, 8'hA1);
        reg_wr(2'd0, 8'h21);
        reg_rd(2'd0, 0, d); chk(d == 8'h21, "R5", "cleared by writing 0", d, 8'h21);
        reg_wr(2'd0, 8'hE1);
        reg_rd(2'd0, 0, d); chk(d == 8'h21, "R5", "writing 1 does not set flags", d, 8'h21);

        // Timer-paced master (R2)
        reg_wr(2'd0, 8'h23);
        tmr_on = 1'b1;
        mxfer(8'h96, 8'h69, 5);
        tmr_on = 1'b0;
        chk(toggles == 16 && gap_bad == 0, "R2", "one change per timer pulse", toggles*100+gap_bad, 1600);
        reg_rd(2'd1, 1, d); chk(d == 8'h69 && m_rx == 8'h96, "R2", "timer mode exchange", {d, m_rx}, 16'h6996);

        // Disabled port (R8)
        reg_wr(2'd0, 8'h00);
        reg_wr(2'd1, 8'h55);
        repeat (10) @(negedge clk);
        reg_rd(2'd2, 0, s); chk(s[1] == 1'b0, "R8", "write while disabled starts nothing", s, 0);
        chk(!sck_oe && !sdo_oe, "R8", "pins undriven when disabled", {sck_oe, sdo_oe}, 0);

        // Slave with gating, select low (R9, R10)
        ss_n_i = 1'b0; sck_i = 1'b0;
        reg_wr(2'd0, 8'h24);
        repeat (4) @(negedge clk);
        reg_wr(2'd1, 8'hA5);
        sxfer(8'h3C, 1'b0, miso);
        chk(miso == 8'hA5, "R9", "slave bits sent MSB first", miso, 8'hA5);
        reg_rd(2'd2, 0, s); chk(s[0] == 1'b1, "R10", "slave full after receive", s, 1);
        reg_rd(2'd1, 1, d); chk(d == 8'h3C, "R9", "slave byte received", d, 8'h3C);

        // Slave overflow (R6)
        reg_wr(2'd1, 8'h12);
        sxfer(8'h77, 1'b0, miso);
        sxfer(8'h88, 1'b0, miso);
        reg_rd(2'd0, 0, d); chk(d[6] == 1'b1, "R6", "overflow flag set", d, 8'h64);
        reg_rd(2'd1, 1, d); chk(d == 8'h77, "R6", "new byte discarded", d, 8'h77);
        reg_rd(2'd0, 0, d); chk(d == 8'h64, "R6", "overflow flag sticky", d, 8'h64);
        reg_wr(2'd0, 8'h24);
        reg_rd(2'd0, 0, d); chk(d == 8'h24, "R6", "overflow cleared by writing 0", d, 8'h24);

        // Select gating resets a partial byte (R3)
        reg_wr(2'd1, 8'h5B);
        sclk_bit(1'b1, 1'b0, g);
        sclk_bit(1'b0, 1'b0, g);
        sclk_bit(1'b1, 1'b0, g);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b0, "R3", "data out released with select high", sdo_oe, 0);
        reg_rd(2'd2, 0, s); chk(s[1] == 1'b0, "R3", "counter reset by select", s, 0);
        sclk_bit(1'b1, 1'b0, g);
        reg_rd(2'd2, 0, s); chk(s == 8'h00, "R3", "edges ignored with select high", s, 0);
        ss_n_i = 1'b0;
        repeat (4) @(negedge clk);
        reg_wr(2'd1, 8'h96);
        sxfer(8'hC3, 1'b0, miso);
        chk(miso == 8'h96, "R3", "full byte after re-select", miso, 8'h96);
        reg_rd(2'd1, 1, d); chk(d == 8'hC3, "R3", "byte aligned after re-select", d, 8'hC3);

        // Slave ignoring select (R3)
        ss_n_i = 1'b1;
        reg_wr(2'd0, 8'h25);
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b1, "R3", "ungated slave drives data out", sdo_oe, 1);
        reg_wr(2'd1, 8'h3A);
        sxfer(8'h5D, 1'b0, miso);
        chk(miso == 8'h3A, "R3", "ungated slave sends", miso, 8'h3A);
        reg_rd(2'd1, 1, d); chk(d == 8'h5D, "R3", "ungated slave receives", d, 8'h5D);

        // Slave with idle-high clock (R4)
        reg_wr(2'd0, 8'h00);
        sck_i = 1'b1;
        repeat (4) @(negedge clk);
        reg_wr(2'd0, 8'h35);
        repeat (4) @(negedge clk);
        reg_wr(2'd1, 8'hE1);
        sxfer(8'h1E, 1'b1, miso);
        chk(miso == 8'hE1, "R4", "slave polarity 1 sends", miso, 8'hE1);
        reg_rd(2'd1, 1, d); chk(d == 8'h1E, "R4", "slave polarity 1 receives", d, 8'h1E);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule